// File: doc/BRIEF.md
# Programmable Synchronous Serial Port

This block is a word-addressed serial port that shifts frames of 4 to 16 bits in either direction. As a master it generates the serial clock, the outgoing data line and an active-low select from its own clock through a two-stage divider: an even prescaler followed by a rate multiplier. As a slave it follows an external clock and select, which it brings into its own clock domain through synchronizers. Clock polarity and phase are programmable. Each direction has an 8-entry FIFO behind a single data register.

Software sets the format and rate while the port is off, then enables it and writes words to the data register. Each transmitted frame yields one received word, which is read back from the same register. Word addresses are: 0 format control, 1 mode control, 2 data, 3 status, 4 prescale. A loopback mode routes the outgoing bit stream back into the receiver. In slave mode a disable bit keeps the data output undriven.

Top module: `sync_serial_port`

## Requirements
- R1: After reset the format control reads 0, mode control reads 0, prescale reads 2, status reads 0x0002, `sel_n_out` is 1 and `miso_oe` is 0.
- R2: Prescale register bit 0 always reads 0, whatever value is written; bits [7:1] hold what was written.
- R3: A master frame of N bits is sent MSB first. The received word is right-justified with zeros above bit N-1, and each transmitted word yields exactly one received word. This holds for every polarity (format bit 6) and phase (format bit 7) combination.
- R4: Format bits [3:0] hold N-1. The values 0 to 2 act as a 4-bit frame.
- R5: While no master frame is in progress, `sclk_out` rests at the level of format bit 6.
- R6: Each half period of `sclk_out` lasts (prescale/2)*(SCR+1) clock cycles, where SCR is format bits [15:8]. A prescale below 2 acts as 2.
- R7: `sel_n_out` goes low one half bit period before the first clock edge of a frame and returns high on the last edge.
- R8: Each FIFO holds 8 words, in order. A write to a full transmit FIFO is dropped, and a data read from an empty receive FIFO returns 0.
- R9: Status bit 1 is set while the transmit FIFO is not full. Bit 2 is set while the receive FIFO is not empty. Bit 4 is set while a frame is in progress or transmit words wait. All other bits read 0.
- R10: With mode bit 0 (loopback) set, the receiver takes the outgoing bit and ignores `miso_in`. With it clear, a master samples `miso_in`.
- R11: With mode bit 2 set (slave), the port shifts `mosi_in` in on `sclk_in` edges while `sel_n_in` is low. It drives `miso_out` MSB first from the transmit FIFO and raises `miso_oe` while selected.
- R12: In slave mode, mode bit 3 forces `miso_oe` to 0.
- R13: No frame starts and no transmit word is consumed while mode bit 1 (enable) is clear or format bits [5:4] are not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive data) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| sclk_out | output | 1 | Master serial clock |
| mosi_out | output | 1 | Master data out |
| sel_n_out | output | 1 | Master select, active low |
| miso_in | input | 1 | Master data in |
| sclk_in | input | 1 | Slave serial clock |
| sel_n_in | input | 1 | Slave select, active low |
| mosi_in | input | 1 | Slave data in |
| miso_out | output | 1 | Slave data out |
| miso_oe | output | 1 | Slave data output enable |

## Verification
The hardest condition to reach from the ports is a transmit FIFO that is full while a ninth word arrives. A running port drains it at once. The stimulus therefore queues nine words with the port disabled, shows that nothing moves and that the not-full flag has dropped, then enables loopback and drains eight frames in order. Slave behaviour needs an external clock the bench shapes by hand, with each edge held long enough to cross the synchronizers, so that the level on `miso_out` can be caught just before each sampling edge.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int FRAME_MAX = 16;

  localparam logic [2:0] REG_FMT  = 3'd0;
  localparam logic [2:0] REG_MODE = 3'd1;
  localparam logic [2:0] REG_DATA = 3'd2;
  localparam logic [2:0] REG_STAT = 3'd3;
  localparam logic [2:0] REG_PSC  = 3'd4;

  // mode control bit positions
  localparam int MODE_LOOP = 0;
  localparam int MODE_EN   = 1;
  localparam int MODE_SLV  = 2;
  localparam int MODE_SOD  = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_GAP   = 2'd3
  } eng_state_t;
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rptr_q];

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (do_push) wptr_d = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
    if (do_pop)  rptr_d = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= push_data;
  end
endmodule

// File: rtl/ssp_rate.sv
module ssp_rate #(
  parameter int PSC_W = 8,
  parameter int SCR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] psc,
  input  logic [SCR_W-1:0] scr,
  output logic             tick
);
  localparam int LEN_W = PSC_W + SCR_W;

  logic [PSC_W-2:0] psc_half;
  logic [LEN_W-1:0] half_len, cnt_q, cnt_d;

  // half period = (prescale / 2) * (scr + 1), prescale below 2 acts as 2
  assign psc_half = (psc[PSC_W-1:1] == '0) ? (PSC_W-1)'(1) : psc[PSC_W-1:1];
  assign half_len = LEN_W'(psc_half) * (LEN_W'(scr) + LEN_W'(1));
  assign tick     = run && (cnt_q == half_len - LEN_W'(1));

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + LEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ssp_engine.sv
module ssp_engine
  import ssp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         slave,
  input  logic         loop,
  input  logic         sod,
  input  logic         cpol,
  input  logic         cpha,
  input  logic [4:0]   nbits,
  input  logic         tick,
  input  logic         tx_valid,
  input  logic [W-1:0] tx_word,
  output logic         tx_pop,
  output logic         rx_push,
  output logic [W-1:0] rx_word,
  output logic         run,
  output logic         busy,
  output logic         sclk_out,
  output logic         mosi_out,
  output logic         sel_n_out,
  input  logic         miso_in,
  input  logic         sclk_in,
  input  logic         sel_n_in,
  input  logic         mosi_in,
  output logic         miso_out,
  output logic         miso_oe
);
  eng_state_t state_q, state_d;
  logic [5:0]   cnt_q, cnt_d, last_idx;
  logic [W-1:0] tx_q, tx_d, rx_q, rx_d, rx_next, load_val;
  logic         sclk_q, sclk_d, sel_q, sel_d;
  logic [2:0]   s_sclk, s_sel;
  logic [1:0]   s_mosi;
  logic         sel_act, sel_fall, sclk_chg, ser_in;
  logic         edge_now, sample_now, shift_now, last;

  assign sel_act  = !s_sel[1];
  assign sel_fall = s_sel[2] && !s_sel[1];
  assign sclk_chg = s_sclk[1] ^ s_sclk[2];

  assign last_idx   = {nbits, 1'b0} - 6'd1;
  assign last       = (cnt_q == last_idx);
  assign sample_now = cpha ? cnt_q[0] : !cnt_q[0];
  assign shift_now  = cpha ? (!cnt_q[0] && cnt_q != 6'd0) : cnt_q[0];
  assign ser_in     = loop ? tx_q[W-1] : (slave ? s_mosi[1] : miso_in);
  assign rx_next    = sample_now ? {rx_q[W-2:0], ser_in} : rx_q;
  assign load_val   = tx_word << (5'd16 - nbits);
  assign edge_now   = slave ? (sel_act && sclk_chg)
                            : (((state_q == ST_LEAD) || (state_q == ST_SHIFT)) && tick);

  assign rx_word   = rx_next;
  assign run       = (state_q != ST_IDLE);
  assign busy      = run || (slave && en && sel_act && cnt_q != 6'd0);
  assign sclk_out  = sclk_q;
  assign sel_n_out = sel_q;
  assign mosi_out  = tx_q[W-1];
  assign miso_out  = tx_q[W-1];
  assign miso_oe   = en && slave && sel_act && !sod;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    tx_d    = tx_q;
    rx_d    = rx_q;
    sclk_d  = sclk_q;
    sel_d   = sel_q;
    tx_pop  = 1'b0;
    rx_push = 1'b0;
    if (!en) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      sclk_d  = cpol;
      sel_d   = 1'b1;
    end else if (slave) begin
      state_d = ST_IDLE;
      sclk_d  = cpol;
      sel_d   = 1'b1;
      if (!sel_act) begin
        cnt_d = '0;
      end else if (sel_fall || (edge_now && last)) begin
        rx_push = edge_now && last;
        tx_pop  = tx_valid;
        tx_d    = tx_valid ? load_val : '0;
        rx_d    = '0;
        cnt_d   = '0;
      end else if (edge_now) begin
        cnt_d = cnt_q + 6'd1;
        rx_d  = rx_next;
        if (shift_now) tx_d = tx_q << 1;
      end
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          sclk_d = cpol;
          sel_d  = 1'b1;
          cnt_d  = '0;
          if (tx_valid) begin
            tx_pop  = 1'b1;
            tx_d    = load_val;
            rx_d    = '0;
            sel_d   = 1'b0;
            state_d = ST_LEAD;
          end
        end
        ST_LEAD, ST_SHIFT: begin
          if (edge_now) begin
            cnt_d  = cnt_q + 6'd1;
            rx_d   = rx_next;
            sclk_d = !sclk_q;
            if (shift_now) tx_d = tx_q << 1;
            if (last) begin
              rx_push = 1'b1;
              sel_d   = 1'b1;
              state_d = ST_GAP;
            end else begin
              state_d = ST_SHIFT;
            end
          end
        end
        ST_GAP: begin
          sclk_d = cpol;
          if (tick) state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      sclk_q  <= 1'b0;
      sel_q   <= 1'b1;
      s_sclk  <= '0;
      s_sel   <= '1;
      s_mosi  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      tx_q    <= tx_d;
      rx_q    <= rx_d;
      sclk_q  <= sclk_d;
      sel_q   <= sel_d;
      s_sclk  <= {s_sclk[1:0], sclk_in};
      s_sel   <= {s_sel[1:0], sel_n_in};
      s_mosi  <= {s_mosi[0], mosi_in};
    end
  end
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import ssp_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int ADDR_W     = 3,
  parameter int BUS_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              sclk_out,
  output logic              mosi_out,
  output logic              sel_n_out,
  input  logic              miso_in,
  input  logic              sclk_in,
  input  logic              sel_n_in,
  input  logic              mosi_in,
  output logic              miso_out,
  output logic              miso_oe
);
  localparam int W = FRAME_MAX;

  logic [1:0]   rsync;
  logic         rst_n_s;
  logic [W-1:0] fmt_q, fmt_d;
  logic [3:0]   mode_q, mode_d;
  logic [7:1]   psc_q, psc_d;
  logic         wr_fmt, wr_mode, wr_psc, wr_data, rd_data;
  logic         en_eff;
  logic [4:0]   nbits;
  logic         tx_full, tx_empty, rx_full, rx_empty;
  logic [W-1:0] tx_head, rx_head, rx_word;
  logic         tx_pop, rx_push, tick, run, busy, busy_any;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_n_s = rsync[1];

  assign wr_fmt  = bus_wr && (bus_addr == REG_FMT);
  assign wr_mode = bus_wr && (bus_addr == REG_MODE);
  assign wr_psc  = bus_wr && (bus_addr == REG_PSC);
  assign wr_data = bus_wr && (bus_addr == REG_DATA);
  assign rd_data = bus_rd && (bus_addr == REG_DATA);

  always_comb begin
    fmt_d  = wr_fmt  ? bus_wdata[W-1:0] : fmt_q;
    mode_d = wr_mode ? bus_wdata[3:0]   : mode_q;
    psc_d  = wr_psc  ? bus_wdata[7:1]   : psc_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      fmt_q  <= '0;
      mode_q <= '0;
      psc_q  <= 7'd1;
    end else begin
      fmt_q  <= fmt_d;
      mode_q <= mode_d;
      psc_q  <= psc_d;
    end
  end

  assign en_eff   = mode_q[MODE_EN] && (fmt_q[5:4] == 2'b00);
  assign nbits    = (fmt_q[3:0] < 4'd3) ? 5'd4 : {1'b0, fmt_q[3:0]} + 5'd1;
  assign busy_any = busy || !tx_empty;

  always_comb begin
    unique case (bus_addr)
      REG_FMT:  bus_rdata = BUS_W'(fmt_q);
      REG_MODE: bus_rdata = BUS_W'(mode_q);
      REG_DATA: bus_rdata = rx_empty ? '0 : BUS_W'(rx_head);
      REG_STAT: bus_rdata = BUS_W'({busy_any, 1'b0, !rx_empty, !tx_full, 1'b0});
      REG_PSC:  bus_rdata = BUS_W'({psc_q, 1'b0});
      default:  bus_rdata = '0;
    endcase
  end

  ssp_fifo #(.WIDTH(W), .DEPTH(FIFO_DEPTH)) i_tx_fifo (
    .clk(clk), .rst_n(rst_n_s),
    .push(wr_data), .push_data(bus_wdata[W-1:0]),
    .pop(tx_pop), .head(tx_head), .full(tx_full), .empty(tx_empty)
  );

  ssp_fifo #(.WIDTH(W), .DEPTH(FIFO_DEPTH)) i_rx_fifo (
    .clk(clk), .rst_n(rst_n_s),
    .push(rx_push), .push_data(rx_word),
    .pop(rd_data), .head(rx_head), .full(rx_full), .empty(rx_empty)
  );

  ssp_rate #(.PSC_W(8), .SCR_W(8)) i_rate (
    .clk(clk), .rst_n(rst_n_s), .run(run),
    .psc({psc_q, 1'b0}), .scr(fmt_q[15:8]), .tick(tick)
  );

  ssp_engine #(.W(W)) i_engine (
    .clk(clk), .rst_n(rst_n_s),
    .en(en_eff), .slave(mode_q[MODE_SLV]), .loop(mode_q[MODE_LOOP]),
    .sod(mode_q[MODE_SOD]), .cpol(fmt_q[6]), .cpha(fmt_q[7]),
    .nbits(nbits), .tick(tick),
    .tx_valid(!tx_empty), .tx_word(tx_head), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_word(rx_word), .run(run), .busy(busy),
    .sclk_out(sclk_out), .mosi_out(mosi_out), .sel_n_out(sel_n_out),
    .miso_in(miso_in), .sclk_in(sclk_in), .sel_n_in(sel_n_in),
    .mosi_in(mosi_in), .miso_out(miso_out), .miso_oe(miso_oe)
  );
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic        slave,
  input logic        sod,
  input logic        cpol,
  input logic        sel_n_out,
  input logic        sclk_out,
  input logic        miso_oe,
  input logic        busy,
  input logic        rx_empty,
  input logic        addr_is_data,
  input logic [15:0] rdata,
  input logic        tx_pop
);
  AST_SEL_HIGH_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !$past(en)) |-> sel_n_out); // R13

  AST_NO_POP_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !tx_pop); // R13

  AST_OE_ONLY_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> (en && slave && !sod)); // R12

  AST_SCLK_RESTS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n_out && $stable(cpol)) |-> (sclk_out == cpol)); // R5

  AST_SEL_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_n_out |-> busy); // R9

  AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_is_data && rx_empty) |-> (rdata == 16'h0000)); // R8
endmodule

bind sync_serial_port ssp_checker i_chk (
  .clk(clk), .rst_n(rst_n_s), .en(en_eff), .slave(mode_q[2]),
  .sod(mode_q[3]), .cpol(fmt_q[6]), .sel_n_out(sel_n_out),
  .sclk_out(sclk_out), .miso_oe(miso_oe), .busy(busy),
  .rx_empty(rx_empty), .addr_is_data(bus_addr == 3'd2),
  .rdata(bus_rdata), .tx_pop(tx_pop)
);

// File: tb/test_sync_serial_port.sv
module test_sync_serial_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        sclk_out, mosi_out, sel_n_out, miso_out, miso_oe;
  logic        miso_in = 1'b1, sclk_in = 1'b0, sel_n_in = 1'b1, mosi_in = 1'b0;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #4 clk = ~clk;

  sync_serial_port i_sync_serial_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk_out(sclk_out), .mosi_out(mosi_out), .sel_n_out(sel_n_out),
    .miso_in(miso_in), .sclk_in(sclk_in), .sel_n_in(sel_n_in),
    .mosi_in(mosi_in), .miso_out(miso_out), .miso_oe(miso_oe)
  );

  // {format, prescale, tx word, expected rx word}, master loopback
  localparam logic [55:0] VECS [6] = '{
    56'h0007_02_00A5_00A5,
    56'h004F_04_BEEF_BEEF,
    56'h0083_02_123C_000C,
    56'h01CB_06_F5A3_05A3,
    56'h0001_02_00F9_0009,
    56'h0209_02_0C01_0001
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int k = 0; k < 3000; k++) begin
      rd(3'd3, s);
      if (s[4] == 1'b0) break;
    end
  endtask

  initial begin
    logic [15:0] v;
    logic [7:0]  cap;
    int t0, t1, t3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(3'd0, v); check("R1 format reset", v, 16'h0000);
    rd(3'd1, v); check("R1 mode reset", v, 16'h0000);
    rd(3'd4, v); check("R1 prescale reset", v, 16'h0002);
    rd(3'd3, v); check("R1 status reset", v, 16'h0002);
    check("R1 select idle", {15'b0, sel_n_out}, 16'h0001);
    check("R1 miso undriven", {15'b0, miso_oe}, 16'h0000);

    // R2 prescale LSB
    wr(3'd4, 16'h0007); rd(3'd4, v); check("R2 prescale odd write", v, 16'h0006);

    // R5 clock rest level follows polarity
    wr(3'd0, 16'h0047); repeat (3) @(negedge clk);
    check("R5 rest high", {15'b0, sclk_out}, 16'h0001);
    wr(3'd0, 16'h0007); repeat (3) @(negedge clk);
    check("R5 rest low", {15'b0, sclk_out}, 16'h0000);

    // R8 / R13: fill the transmit FIFO while disabled
    wr(3'd4, 16'h0002);
    for (int i = 0; i < 9; i++) wr(3'd2, 16'h0010 + 16'(i));
    rd(3'd3, v); check("R8 tx full status", v, 16'h0010);
    repeat (40) @(negedge clk);
    check("R13 no frame while disabled", {15'b0, sel_n_out}, 16'h0001);
    wr(3'd1, 16'h0003);
    wait_idle();
    for (int i = 0; i < 8; i++) begin
      rd(3'd2, v); check("R8 fifo order", v, 16'h0010 + 16'(i));
    end
    rd(3'd2, v); check("R8 dropped word and empty read", v, 16'h0000);

    // R3 R4 R9 R10 table walk, loopback with miso_in held high
    miso_in = 1'b1;
    for (int i = 0; i < 6; i++) begin
      logic [55:0] e;
      e = VECS[i];
      wr(3'd1, 16'h0000);
      wr(3'd0, e[55:40]);
      wr(3'd4, {8'h00, e[39:32]});
      wr(3'd1, 16'h0003);
      wr(3'd2, e[31:16]);
      wait_idle();
      rd(3'd3, v); check("R9 status after frame", v, 16'h0006);
      rd(3'd2, v); check("R3 R4 R10 loopback word", v, e[15:0]);
      rd(3'd3, v); check("R9 status after read", v, 16'h0002);
    end

    // R6 R7 timing and R10 master sampling miso_in
    wr(3'd1, 16'h0000);
    wr(3'd0, 16'h0107);
    wr(3'd4, 16'h0004);
    wr(3'd1, 16'h0002);
    wr(3'd2, 16'h0055);
    while (sel_n_out !== 1'b0) @(negedge clk);
    t0 = cyc;
    while (sclk_out !== 1'b1) @(negedge clk);
    t1 = cyc;
    while (sclk_out !== 1'b0) @(negedge clk);
    while (sclk_out !== 1'b1) @(negedge clk);
    t3 = cyc;
    check("R7 select lead", 16'(t1 - t0), 16'd4);
    check("R6 sclk period", 16'(t3 - t1), 16'd8);
    wait_idle();
    check("R7 select released", {15'b0, sel_n_out}, 16'h0001);
    rd(3'd2, v); check("R10 miso high sampled", v, 16'h00FF);
    miso_in = 1'b0;
    wr(3'd2, 16'h00FF);
    wait_idle();
    rd(3'd2, v); check("R10 miso low sampled", v, 16'h0000);

    // R11 slave transfer, mode 0
    wr(3'd1, 16'h0000);
    wr(3'd0, 16'h0007);
    wr(3'd2, 16'h003C);
    wr(3'd1, 16'h0006);
    sel_n_in = 1'b0;
    repeat (10) @(negedge clk);
    check("R11 miso driven", {15'b0, miso_oe}, 16'h0001);
    cap = '0;
    for (int b = 7; b >= 0; b--) begin
      mosi_in = b[0] ? 1'b0 : 1'b1;
      mosi_in = 8'h96 >> b;
      repeat (10) @(negedge clk);
      cap = {cap[6:0], miso_out};
      sclk_in = 1'b1;
      repeat (10) @(negedge clk);
      sclk_in = 1'b0;
    end
    repeat (10) @(negedge clk);
    sel_n_in = 1'b1;
    repeat (6) @(negedge clk);
    check("R11 slave output bits", {8'h00, cap}, 16'h003C);
    rd(3'd2, v); check("R11 slave received word", v, 16'h0096);
    check("R11 released", {15'b0, miso_oe}, 16'h0000);

    // R12 slave output disable
    wr(3'd1, 16'h000E);
    sel_n_in = 1'b0;
    repeat (10) @(negedge clk);
    check("R12 output disabled", {15'b0, miso_oe}, 16'h0000);
    sel_n_in = 1'b1;
    repeat (6) @(negedge clk);

    finish_run();
  end
endmodule